// File: doc/BRIEF.md
# Transactional Snooping Cache Controller

This block is a small, fully associative data cache that gives a processor hardware transactions. Every slot holds one word with an address, a coherence state and a transactional tag. The first time a transaction touches a word, the controller keeps two entries for it. One entry is the working copy and is thrown away if the transaction rolls back. The other is the pre-image and is thrown away if the transaction commits. A commit or a rollback rewrites every tag in a single cycle.

The processor sends requests on a valid/ready channel. The request codes are:

| Code | Request |
|------|---------|
| 0 | transactional load (shared) |
| 1 | transactional load-exclusive |
| 2 | transactional store |
| 3 | validate |
| 4 | commit |
| 5 | abort |

A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The requester must hold `req_valid`, `req_op`, `req_addr` and `req_wdata` steady until then. `req_ready` is low while a bus fetch is outstanding and in any cycle that carries a snoop, because a snoop has priority over a processor request. Every request that is taken produces exactly one single-cycle `rsp_valid` pulse, and the requester must take it.

On a miss, or when write permission is missing, the controller issues a transactional bus fetch. It keeps `bus_req_valid`, the address and the kind steady until a reply is taken, which happens on a clock edge where both `bus_rsp_valid` and `bus_rsp_ready` are high. The responder must hold its reply until then. Bus-cycle kinds are encoded as:

| Code | Bus cycle |
|------|-----------|
| 0 | shared read |
| 1 | read for ownership |
| 2 | write-back |
| 3 | transactional shared read |
| 4 | transactional exclusive read |

The snoop port reports requests made by other agents. Kinds 1, 2 and 4 are exclusive; kinds 0 and 3 are shared. `snp_busy` answers the snoop in the same cycle.

Line states are invalid, valid (shared, read only), dirty (owned and modified) and reserved (owned and clean). Tags are empty, normal, discard-on-commit and discard-on-abort.

Top module: `txc_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_req_valid` is 0 and `rsp_valid` is 0, and a validate request answers `rsp_ok`=1.
- R2: A load (code 0) that misses issues one bus fetch of kind 3 at the request address. If the reply is not BUSY, the load answers `rsp_ok`=1 with the bus data. The fetch stays stable until its reply is taken.
- R3: A load of a word that already has a working copy in this transaction answers that copy's value with no bus cycle.
- R4: A load-exclusive (code 1) that misses issues one bus fetch of kind 4 and answers the bus data.
- R5: A store (code 2) changes only the working copy: a later load in the same transaction reads the stored value, and after an abort a load reads the value from before the store. Working copies and pre-images always exist in equal numbers.
- R6: Validate, commit and abort each answer on the cycle after they are taken. Commit answers `rsp_ok`=1 when the transaction is live, and after it a load reads the committed value with no bus cycle.
- R7: A BUSY bus reply makes the request fail (`rsp_ok`=0) and marks the transaction aborted. After that, memory requests fail with no bus cycle, validate answers 0, commit answers 0 and rolls back, and the next validate answers 1.
- R8: An exclusive snoop (kinds 1, 2, 4) that hits a word touched by the live transaction gets `snp_busy`=1. A shared snoop (kinds 0, 3) on a word read only for sharing gets `snp_busy`=0 and has no effect.
- R9: A shared snoop that hits a word the transaction holds exclusively (after a load-exclusive or a store) aborts the transaction, so the next validate answers 0.
- R10: When there are not enough empty slots for a memory request (two for a miss, one for a committed-line hit), the request fails with no bus cycle and the transaction is aborted.
- R11: A load of a word held with a normal tag answers its value with no bus cycle.
- R12: An exclusive snoop that hits a normal-tagged word invalidates it, so the next load of that word fetches it over the bus.
- R13: A store or load-exclusive to a word held only in the shared state first issues a kind 4 bus fetch to gain ownership.
- R14: `req_ready` is 0 while a bus fetch is outstanding and in any cycle where `snp_valid` is 1. `bus_rsp_ready` is 0 in any cycle where `snp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_op | input | 3 | Request code (0..5) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_ok | output | 1 | Success, or validate result |
| rsp_data | output | DW | Value of the working copy after the request |
| bus_req_valid | output | 1 | Bus fetch outstanding |
| bus_req_kind | output | 3 | Bus cycle kind (3 or 4) |
| bus_req_addr | output | AW | Fetch address |
| bus_rsp_valid | input | 1 | Bus reply present |
| bus_rsp_ready | output | 1 | Reply taken on this edge if valid |
| bus_rsp_busy | input | 1 | Reply is BUSY (access refused) |
| bus_rsp_data | input | DW | Reply data |
| snp_valid | input | 1 | Snooped request from another agent |
| snp_kind | input | 3 | Snooped bus cycle kind |
| snp_addr | input | AW | Snooped address |
| snp_busy | output | 1 | Refuse the snooped request |

## Verification
Directed sequences follow one word through every path:
- miss, hit on the working copy, ownership upgrade, store, abort, commit and reload;
- each of these separates the bus-fetch, no-bus and rollback outcomes of a lookup.

A BUSY reply, a shared snoop on an owned word and a full cache each force an abort. The bench checks each of these forced aborts for both the failed request and the validate result that follows.

A seeded random phase mixes loads and stores with commits and aborts over four words, and flushes words from time to time with exclusive snoops. It compares every returned value with a model of the committed data. This shows whether the value comes from the bus, from a committed line or from a store that was kept or rolled back.

// File: rtl/txc_pkg.sv
package txc_pkg;
  typedef enum logic [1:0] {TG_EMPTY = 2'd0, TG_NORMAL = 2'd1, TG_XCOMMIT = 2'd2, TG_XABORT = 2'd3} tag_e;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_VALID = 2'd1, LS_DIRTY = 2'd2, LS_RESV = 2'd3} lstate_e;
  localparam logic [2:0] OP_LT = 3'd0, OP_LTX = 3'd1, OP_ST = 3'd2;
  localparam logic [2:0] OP_VALIDATE = 3'd3, OP_COMMIT = 3'd4, OP_ABORT = 3'd5;
  localparam logic [2:0] BK_READ = 3'd0, BK_RFO = 3'd1, BK_WRITE = 3'd2, BK_TREAD = 3'd3, BK_TRFO = 3'd4;
endpackage

// File: rtl/txc_match.sv
module txc_match
  import txc_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 8,
  localparam int IW = $clog2(N)
) (
  input  tag_e  [N-1:0]         tags,
  input  logic  [N-1:0][AW-1:0] addrs,
  input  logic  [AW-1:0]        key,
  output logic                  xa_hit,
  output logic  [IW-1:0]        xa_idx,
  output logic                  nm_hit,
  output logic  [IW-1:0]        nm_idx,
  output logic                  fr0_ok,
  output logic  [IW-1:0]        fr0_idx,
  output logic                  fr1_ok,
  output logic  [IW-1:0]        fr1_idx
);
  logic seen;

  always_comb begin
    xa_hit = 1'b0; xa_idx = '0;
    nm_hit = 1'b0; nm_idx = '0;
    fr0_ok = 1'b0; fr0_idx = '0;
    // descending scan: the lowest matching slot is assigned last and wins
    for (int i = N - 1; i >= 0; i--) begin
      if (tags[i] == TG_XABORT && addrs[i] == key) begin
        xa_hit = 1'b1; xa_idx = IW'(i);
      end
      if (tags[i] == TG_NORMAL && addrs[i] == key) begin
        nm_hit = 1'b1; nm_idx = IW'(i);
      end
      if (tags[i] == TG_EMPTY) begin
        fr0_ok = 1'b1; fr0_idx = IW'(i);
      end
    end
  end

  always_comb begin
    seen = 1'b0; fr1_ok = 1'b0; fr1_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (tags[i] == TG_EMPTY) begin
        if (!seen) seen = 1'b1;
        else if (!fr1_ok) begin
          fr1_ok = 1'b1; fr1_idx = IW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/txc_snoop.sv
module txc_snoop
  import txc_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 8
) (
  input  tag_e    [N-1:0]         tags,
  input  lstate_e [N-1:0]         states,
  input  logic    [N-1:0][AW-1:0] addrs,
  input  logic                    snp_valid,
  input  logic    [2:0]           snp_kind,
  input  logic    [AW-1:0]        snp_addr,
  output logic                    snp_busy,
  output logic                    snp_kill,
  output logic    [N-1:0]         inval
);
  logic [N-1:0] hit, xmask, owned, nmask;
  logic excl;

  assign excl = (snp_kind == BK_RFO) || (snp_kind == BK_WRITE) || (snp_kind == BK_TRFO);

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign hit[i]   = snp_valid && (addrs[i] == snp_addr);
    assign xmask[i] = (tags[i] == TG_XABORT) || (tags[i] == TG_XCOMMIT);
    assign nmask[i] = (tags[i] == TG_NORMAL);
    assign owned[i] = (tags[i] == TG_XABORT) &&
                      ((states[i] == LS_RESV) || (states[i] == LS_DIRTY));
  end

  assign snp_busy = excl && |(hit & xmask);
  assign snp_kill = !excl && |(hit & owned);
  assign inval    = excl ? (hit & nmask) : '0;
endmodule

// File: rtl/txc_cache.sv
module txc_cache
  import txc_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [DW-1:0] rsp_data,
  output logic          bus_req_valid,
  output logic [2:0]    bus_req_kind,
  output logic [AW-1:0] bus_req_addr,
  input  logic          bus_rsp_valid,
  output logic          bus_rsp_ready,
  input  logic          bus_rsp_busy,
  input  logic [DW-1:0] bus_rsp_data,
  input  logic          snp_valid,
  input  logic [2:0]    snp_kind,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_busy
);
  typedef enum logic {S_IDLE, S_BUS} fsm_e;

  tag_e    [N-1:0]         tag_q;
  lstate_e [N-1:0]         st_q;
  logic    [N-1:0][AW-1:0] adr_q;
  logic    [N-1:0][DW-1:0] dat_q;
  fsm_e                    fsm_q;
  logic                    dead_q;
  logic    [2:0]           op_q;
  logic    [AW-1:0]        addr_q;
  logic    [DW-1:0]        wd_q;

  logic [2:0]    op_c;
  logic [AW-1:0] key;
  logic [DW-1:0] wd_c;
  logic          xa_hit, nm_hit, fr0_ok, fr1_ok;
  logic [IW-1:0] xa_idx, nm_idx, fr0_idx, fr1_idx;
  logic          snp_kill;
  logic [N-1:0]  inval;

  assign op_c = (fsm_q == S_IDLE) ? req_op : op_q;
  assign key  = (fsm_q == S_IDLE) ? req_addr : addr_q;
  assign wd_c = (fsm_q == S_IDLE) ? req_wdata : wd_q;

  txc_match #(.N(N), .AW(AW)) u_match (
    .tags(tag_q), .addrs(adr_q), .key(key),
    .xa_hit(xa_hit), .xa_idx(xa_idx), .nm_hit(nm_hit), .nm_idx(nm_idx),
    .fr0_ok(fr0_ok), .fr0_idx(fr0_idx), .fr1_ok(fr1_ok), .fr1_idx(fr1_idx)
  );

  txc_snoop #(.N(N), .AW(AW)) u_snoop (
    .tags(tag_q), .states(st_q), .addrs(adr_q),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .snp_busy(snp_busy), .snp_kill(snp_kill), .inval(inval)
  );

  assign req_ready     = (fsm_q == S_IDLE) && !snp_valid;
  assign bus_req_valid = (fsm_q == S_BUS);
  assign bus_rsp_ready = (fsm_q == S_BUS) && !snp_valid;
  assign bus_req_addr  = addr_q;
  assign bus_req_kind  = (op_q == OP_LT) ? BK_TREAD : BK_TRFO;

  logic          acc, is_mem, excl, is_st, miss, upg, room, done_bus;
  logic          install, go_bus, fail_mem, rollback, commit_go;
  lstate_e       hit_st, pre_st, xa_st;
  logic [DW-1:0] base_d, xa_d;

  always_comb begin
    acc      = req_valid && req_ready;
    done_bus = (fsm_q == S_BUS) && bus_rsp_valid && bus_rsp_ready;
    is_mem   = (op_c == OP_LT) || (op_c == OP_LTX) || (op_c == OP_ST);
    excl     = (op_c == OP_LTX) || (op_c == OP_ST);
    is_st    = (op_c == OP_ST);
    hit_st   = xa_hit ? st_q[xa_idx] : st_q[nm_idx];
    miss     = !xa_hit && !nm_hit;
    upg      = excl && !miss && (hit_st == LS_VALID);
    room     = xa_hit || (nm_hit && fr0_ok) || (fr0_ok && fr1_ok);
    // data fetched or permission granted over the bus sets the pre-image state
    pre_st   = (fsm_q == S_BUS) ? (excl ? LS_RESV : LS_VALID) : hit_st;
    xa_st    = is_st ? LS_DIRTY : pre_st;
    base_d   = miss ? bus_rsp_data : (xa_hit ? dat_q[xa_idx] : dat_q[nm_idx]);
    xa_d     = is_st ? wd_c : base_d;

    go_bus   = acc && is_mem && !dead_q && room && (miss || upg);
    install  = (acc && is_mem && !dead_q && room && !(miss || upg)) ||
               (done_bus && !bus_rsp_busy && !dead_q && !snp_kill && room);
    fail_mem = (acc && is_mem && (dead_q || !room)) || (done_bus && !install);
    commit_go = acc && (op_c == OP_COMMIT) && !dead_q;
    rollback = (fail_mem && !dead_q) || snp_kill ||
               (acc && (op_c == OP_ABORT)) || (acc && (op_c == OP_COMMIT) && dead_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= S_IDLE;
      dead_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_data  <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      wd_q      <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= TG_EMPTY;
        st_q[i]  <= LS_INV;
        adr_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (acc) begin
        op_q   <= req_op;
        addr_q <= req_addr;
        wd_q   <= req_wdata;
      end
      if (go_bus) fsm_q <= S_BUS;
      else if (done_bus) fsm_q <= S_IDLE;

      rsp_valid <= (acc && !go_bus) || done_bus;
      rsp_ok    <= install || commit_go || (acc && op_c == OP_ABORT) ||
                   (acc && op_c == OP_VALIDATE && !dead_q);
      rsp_data  <= install ? xa_d : '0;

      if (acc && (op_c == OP_COMMIT || op_c == OP_ABORT)) dead_q <= 1'b0;
      else if ((fail_mem && !dead_q) || snp_kill) dead_q <= 1'b1;

      if (rollback) begin
        for (int i = 0; i < N; i++) begin
          if (tag_q[i] == TG_XABORT) begin
            tag_q[i] <= TG_EMPTY; st_q[i] <= LS_INV;
          end else if (tag_q[i] == TG_XCOMMIT) tag_q[i] <= TG_NORMAL;
        end
      end
      if (commit_go) begin
        for (int i = 0; i < N; i++) begin
          if (tag_q[i] == TG_XCOMMIT) begin
            tag_q[i] <= TG_EMPTY; st_q[i] <= LS_INV;
          end else if (tag_q[i] == TG_XABORT) tag_q[i] <= TG_NORMAL;
        end
      end
      if (install) begin
        if (xa_hit) begin
          st_q[xa_idx]  <= xa_st;
          dat_q[xa_idx] <= xa_d;
        end else if (nm_hit) begin
          tag_q[nm_idx]  <= TG_XABORT;
          st_q[nm_idx]   <= xa_st;
          dat_q[nm_idx]  <= xa_d;
          tag_q[fr0_idx] <= TG_XCOMMIT;
          st_q[fr0_idx]  <= pre_st;
          adr_q[fr0_idx] <= key;
          dat_q[fr0_idx] <= dat_q[nm_idx];
        end else begin
          tag_q[fr0_idx] <= TG_XABORT;
          st_q[fr0_idx]  <= xa_st;
          adr_q[fr0_idx] <= key;
          dat_q[fr0_idx] <= xa_d;
          tag_q[fr1_idx] <= TG_XCOMMIT;
          st_q[fr1_idx]  <= pre_st;
          adr_q[fr1_idx] <= key;
          dat_q[fr1_idx] <= bus_rsp_data;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (inval[i]) begin
          tag_q[i] <= TG_EMPTY; st_q[i] <= LS_INV;
        end
      end
    end
  end
endmodule

// File: rtl/txc_chk.sv
module txc_chk
  import txc_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_op,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic          bus_req_valid,
  input logic [2:0]    bus_req_kind,
  input logic [AW-1:0] bus_req_addr,
  input logic          bus_rsp_valid,
  input logic          bus_rsp_ready,
  input logic          bus_rsp_busy,
  input logic          snp_valid,
  input logic [2:0]    snp_kind,
  input logic          snp_busy,
  input tag_e [N-1:0]  tags
);
  int n_xa, n_xc;
  always_comb begin
    n_xa = 0; n_xc = 0;
    for (int i = 0; i < N; i++) begin
      if (tags[i] == TG_XABORT)  n_xa++;
      if (tags[i] == TG_XCOMMIT) n_xc++;
    end
  end

  AST_PAIR_BALANCE: assert property (@(posedge clk) disable iff (rst) n_xa == n_xc); // R5
  AST_WAIT_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst) bus_req_valid |-> !req_ready); // R14
  AST_SNOOP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> (!req_ready && !bus_rsp_ready)); // R14
  AST_BUSY_EXCL_ONLY: assert property (@(posedge clk) disable iff (rst)
    snp_busy |-> (snp_valid && (snp_kind == BK_RFO || snp_kind == BK_WRITE || snp_kind == BK_TRFO))); // R8
  AST_BUSY_REPLY_FAILS: assert property (@(posedge clk) disable iff (rst)
    (bus_rsp_valid && bus_rsp_ready && bus_rsp_busy) |=> (rsp_valid && !rsp_ok)); // R7
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !(bus_rsp_valid && bus_rsp_ready)) |=>
    (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_kind))); // R2
  AST_CTRL_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_op == OP_VALIDATE || req_op == OP_COMMIT || req_op == OP_ABORT))
    |=> rsp_valid); // R6
endmodule

bind txc_cache txc_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .bus_req_valid(bus_req_valid),
  .bus_req_kind(bus_req_kind), .bus_req_addr(bus_req_addr), .bus_rsp_valid(bus_rsp_valid),
  .bus_rsp_ready(bus_rsp_ready), .bus_rsp_busy(bus_rsp_busy), .snp_valid(snp_valid),
  .snp_kind(snp_kind), .snp_busy(snp_busy), .tags(tag_q)
);

// File: tb/txc_cache_tb.sv
module txc_cache_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_ok;
  logic [15:0] rsp_data;
  logic        bus_req_valid;
  logic [2:0]  bus_req_kind;
  logic [7:0]  bus_req_addr;
  logic        bus_rsp_valid = 1'b0;
  logic        bus_rsp_ready;
  logic        bus_rsp_busy = 1'b0;
  logic [15:0] bus_rsp_data = '0;
  logic        snp_valid = 1'b0;
  logic [2:0]  snp_kind = '0;
  logic [7:0]  snp_addr = '0;
  logic        snp_busy;

  int checks = 0, errors = 0, nbus = 0;
  logic [2:0] last_kind = '0;
  logic [7:0] last_addr = '0;
  bit busy_mode = 1'b0, replying = 1'b0;

  always #5 clk = ~clk;

  txc_cache u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_data(rsp_data), .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
    .bus_req_addr(bus_req_addr), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ready(bus_rsp_ready),
    .bus_rsp_busy(bus_rsp_busy), .bus_rsp_data(bus_rsp_data), .snp_valid(snp_valid),
    .snp_kind(snp_kind), .snp_addr(snp_addr), .snp_busy(snp_busy)
  );

  function automatic logic [15:0] bd(input logic [7:0] a);
    return 16'(a) * 16'd97 + 16'h00A5;
  endfunction

  task automatic check(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scripted remote agent: answers each fetch with data or BUSY
  always @(negedge clk) begin
    if (replying && !bus_req_valid) begin
      replying = 1'b0;
      bus_rsp_valid = 1'b0;
    end else if (!replying && bus_req_valid) begin
      nbus++;
      last_kind = bus_req_kind;
      last_addr = bus_req_addr;
      check(req_ready == 1'b0, "R14 ready during fetch", 32'(req_ready), 0);
      bus_rsp_valid = 1'b1;
      bus_rsp_busy  = busy_mode;
      bus_rsp_data  = bd(bus_req_addr);
      replying = 1'b1;
    end
  end

  task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [15:0] wd,
                       output logic ok, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    ok = rsp_ok; d = rsp_data;
  endtask

  task automatic snoop(input logic [2:0] k, input logic [7:0] a, output logic busy);
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = k; snp_addr = a;
    #1;
    busy = snp_busy;
    check(req_ready == 1'b0, "R14 ready during snoop", 32'(req_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic ok, bz;
    logic [15:0] d;
    int nb;
    logic [15:0] cval [4];
    bit cached [4];

    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    check(bus_req_valid == 1'b0, "R1 bus idle", 32'(bus_req_valid), 0);
    check(rsp_valid == 1'b0, "R1 no rsp", 32'(rsp_valid), 0);
    do_op(3'd3, 8'h0, 16'h0, ok, d);
    check(ok == 1'b1, "R1 validate", 32'(ok), 1);

    nb = nbus;
    do_op(3'd0, 8'h10, 16'h0, ok, d);
    check(nbus == nb + 1 && last_kind == 3'd3 && last_addr == 8'h10, "R2 fetch kind", 32'(last_kind), 3);
    check(ok && d == bd(8'h10), "R2 data", 32'(d), 32'(bd(8'h10)));
    nb = nbus;
    do_op(3'd0, 8'h10, 16'h0, ok, d);
    check(nbus == nb && ok && d == bd(8'h10), "R3 repeat hit", 32'(d), 32'(bd(8'h10)));

    snoop(3'd1, 8'h10, bz);
    check(bz == 1'b1, "R8 excl snoop busy", 32'(bz), 1);
    snoop(3'd0, 8'h10, bz);
    check(bz == 1'b0, "R8 shared snoop allowed", 32'(bz), 0);
    do_op(3'd3, 8'h0, 16'h0, ok, d);
    check(ok == 1'b1, "R8 still live", 32'(ok), 1);

    nb = nbus;
    do_op(3'd2, 8'h10, 16'hBEEF, ok, d);
    check(nbus == nb + 1 && last_kind == 3'd4, "R13 upgrade fetch", 32'(last_kind), 4);
    check(ok && d == 16'hBEEF, "R5 store rsp", 32'(d), 32'hBEEF);
    do_op(3'd0, 8'h10, 16'h0, ok, d);
    check(d == 16'hBEEF, "R5 load after store", 32'(d), 32'hBEEF);
    do_op(3'd5, 8'h0, 16'h0, ok, d);
    check(ok == 1'b1, "R6 abort ok", 32'(ok), 1);
    nb = nbus;
    do_op(3'd0, 8'h10, 16'h0, ok, d);
    check(nbus == nb && d == bd(8'h10), "R5 abort restores / R11 normal hit", 32'(d), 32'(bd(8'h10)));

    nb = nbus;
    do_op(3'd1, 8'h11, 16'h0, ok, d);
    check(nbus == nb + 1 && last_kind == 3'd4 && d == bd(8'h11), "R4 exclusive fetch", 32'(last_kind), 4);
    nb = nbus;
    do_op(3'd2, 8'h11, 16'h1234, ok, d);
    check(nbus == nb && ok, "R13 owned store no bus", 32'(nbus - nb), 0);
    do_op(3'd4, 8'h0, 16'h0, ok, d);
    check(ok == 1'b1, "R6 commit ok", 32'(ok), 1);
    nb = nbus;
    do_op(3'd0, 8'h11, 16'h0, ok, d);
    check(nbus == nb && d == 16'h1234, "R6 committed value", 32'(d), 32'h1234);
    do_op(3'd4, 8'h0, 16'h0, ok, d);

    busy_mode = 1'b1;
    do_op(3'd0, 8'h12, 16'h0, ok, d);
    busy_mode = 1'b0;
    check(ok == 1'b0, "R7 busy reply fails", 32'(ok), 0);
    do_op(3'd3, 8'h0, 16'h0, ok, d);
    check(ok == 1'b0, "R7 validate false", 32'(ok), 0);
    nb = nbus;
    do_op(3'd0, 8'h10, 16'h0, ok, d);
    check(ok == 1'b0 && nbus == nb, "R7 dead op no bus", 32'(ok), 0);
    do_op(3'd4, 8'h0, 16'h0, ok, d);
    check(ok == 1'b0, "R7 commit refused", 32'(ok), 0);
    do_op(3'd3, 8'h0, 16'h0, ok, d);
    check(ok == 1'b1, "R7 fresh after commit", 32'(ok), 1);

    do_op(3'd1, 8'h13, 16'h0, ok, d);
    snoop(3'd0, 8'h13, bz);
    check(bz == 1'b0, "R9 shared snoop not busy", 32'(bz), 0);
    do_op(3'd3, 8'h0, 16'h0, ok, d);
    check(ok == 1'b0, "R9 conflict aborts", 32'(ok), 0);
    do_op(3'd5, 8'h0, 16'h0, ok, d);

    snoop(3'd1, 8'h11, bz);
    check(bz == 1'b0, "R12 normal line not busy", 32'(bz), 0);
    nb = nbus;
    do_op(3'd0, 8'h11, 16'h0, ok, d);
    check(nbus == nb + 1 && d == bd(8'h11), "R12 refetch after inval", 32'(nbus - nb), 1);
    do_op(3'd5, 8'h0, 16'h0, ok, d);
    snoop(3'd1, 8'h10, bz);
    snoop(3'd1, 8'h11, bz);
    snoop(3'd1, 8'h13, bz);

    for (int i = 0; i < 4; i++) begin
      do_op(3'd0, 8'h20 + 8'(i), 16'h0, ok, d);
      check(ok == 1'b1, "R10 fill", 32'(ok), 1);
    end
    nb = nbus;
    do_op(3'd0, 8'h24, 16'h0, ok, d);
    check(ok == 1'b0 && nbus == nb, "R10 full fails no bus", 32'(nbus - nb), 0);
    do_op(3'd3, 8'h0, 16'h0, ok, d);
    check(ok == 1'b0, "R10 aborted", 32'(ok), 0);
    do_op(3'd5, 8'h0, 16'h0, ok, d);
    for (int i = 0; i < 4; i++) snoop(3'd1, 8'h20 + 8'(i), bz);

    for (int i = 0; i < 4; i++) begin cached[i] = 1'b0; cval[i] = '0; end
    for (int it = 0; it < 80; it++) begin
      int a;
      bit isst, cm;
      logic [15:0] wd, er;
      a = int'($urandom % 4);
      isst = 1'($urandom % 2);
      cm = 1'($urandom % 2);
      wd = 16'($urandom);
      er = cached[a] ? cval[a] : bd(8'h40 + 8'(a));
      do_op(isst ? 3'd2 : 3'd0, 8'h40 + 8'(a), wd, ok, d);
      if (isst) check(ok && d == wd, "R5 random store", 32'(d), 32'(wd));
      else if (cached[a]) check(ok && d == er, "R11 random cached load", 32'(d), 32'(er));
      else check(ok && d == er, "R2 random miss load", 32'(d), 32'(er));
      do_op(cm ? 3'd4 : 3'd5, 8'h0, 16'h0, ok, d);
      check(ok == 1'b1, "R6 random end", 32'(ok), 1);
      cached[a] = 1'b1;
      cval[a] = (cm && isst) ? wd : er;
      if ($urandom % 5 == 0) begin
        int f;
        f = int'($urandom % 4);
        snoop(3'd1, 8'h40 + 8'(f), bz);
        check(bz == 1'b0, "R12 random flush", 32'(bz), 0);
        cached[f] = 1'b0;
      end
    end
    summary();
  end
endmodule